// File: doc/BRIEF.md
# Reloadable System Tick Timer

This block produces a steady periodic tick for an operating system or other housekeeping software. Its core is a 24-bit counter that runs downward and restarts from a programmed reload value each time it passes through zero. Each arrival at zero sets a sticky status flag and, if software allows it, raises a one-cycle interrupt request. The counter steps either on every system clock or on every second system clock, which gives a half-rate reference.

Software reaches the block only through a small register bank on a simple peripheral bus. The bank holds a control/status word, the reload value, the live counter value and a fixed calibration word. The calibration word gives the reload value for a 10 ms period. The block has no pins of its own beyond the bus, clock, reset and the interrupt request.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, control/status (offset 0x0), reload (0x4) and current value (0x8) all read as zero, and the interrupt request is low.
- R2: With bit 0 (run) and bit 2 (clock source = 1, full rate) set, the counter drops by one on every clock. From zero it loads the reload value, so one period spans reload+1 counts.
- R3: With bit 2 clear, the counter steps only on the half-rate enable, which is high on every second system clock counted from reset.
- R4: With bit 0 clear, the current value holds.
- R5: Bit 16 of control/status is set when the counter steps from 1 to 0. A read of offset 0x0 returns the flag and clears it. If a set and a clearing read land in the same cycle, the set wins.
- R6: When bit 1 (interrupt enable) is set, a step from 1 to 0 gives a tick_irq pulse exactly one clock long in the following cycle. With bit 1 clear, tick_irq stays low.
- R7: Any write to offset 0x8 clears the counter and the flag. The next active count step then loads the reload value.
- R8: With a reload value of zero, the counter stays at zero once it gets there, and no further flags or interrupts occur.
- R9: Offset 0xC reads the constant calibration value in bits 23:0. Writes to it have no effect.
- R10: Reload keeps only bits 23:0 and reads zero above them. Bit 16 of control/status cannot be written. Unmapped offsets read zero, and bus_rdata is zero unless a read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The hardest case to reach from the ports is a read of control/status that falls in the same cycle as the 1-to-0 step. That read must see the old flag, and the flag must still end up set. A directed sequence covers it with a short reload and a read of offset 0x0 on every cycle, so one of those reads is sure to land on the step. Long random runs add the other overlaps: reload changes just before the counter wraps, clock-source switches against the half-rate phase, and clears of the current value in the middle of a period. A cycle-level bench model compares every read and every cycle of tick_irq.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // Datapath widths
    localparam int CNT_W  = 24;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Byte offsets of the register bank
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_VALUE  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_CALIB  = 4'hC;

    // Bit positions inside control/status
    localparam int BIT_RUN  = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    typedef enum logic [2:0] {
        REG_CTRL,
        REG_RELOAD,
        REG_VALUE,
        REG_CALIB,
        REG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic clk_src;   // 1 = system clock, 0 = half-rate enable
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_CTRL:   s = REG_CTRL;
            OFF_RELOAD: s = REG_RELOAD;
            OFF_VALUE:  s = REG_VALUE;
            OFF_CALIB:  s = REG_CALIB;
            default:    s = REG_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BIT_RUN]  = c.run;
        w[BIT_IE]   = c.irq_en;
        w[BIT_SRC]  = c.clk_src;
        w[BIT_FLAG] = flag;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run     = w[BIT_RUN];
        c.irq_en  = w[BIT_IE];
        c.clk_src = w[BIT_SRC];
        return c;
    endfunction

endpackage

// File: rtl/tick_ref_enable.sv
// Produces a one-cycle enable once every DIV system clocks; no derived clock.
module tick_ref_enable #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic pulse
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign pulse = (phase_q == LAST);
endmodule

// File: rtl/tick_regs.sv
// Register bank: decode, writable state and read-data mux.
module tick_regs
    import tick_pkg::*;
#(
    parameter int               CW          = CNT_W,
    parameter logic [CW-1:0]    CALIB_VALUE = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [CW-1:0]       cur_value,
    input  logic                count_flag,
    output ctrl_t               ctrl,
    output logic [CW-1:0]       reload,
    output logic                value_clear,
    output logic                ctrl_read,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int PAD_W = DATA_W - CW;

    access_t acc;
    ctrl_t   ctrl_q;
    logic [CW-1:0] reload_q;

    always_comb begin
        acc.rd  = bus_sel & ~bus_write;
        acc.wr  = bus_sel &  bus_write;
        acc.sel = decode_addr(bus_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (acc.wr) begin
            case (acc.sel)
                REG_CTRL:   ctrl_q   <= unpack_ctrl(bus_wdata);
                REG_RELOAD: reload_q <= bus_wdata[CW-1:0];
                default:    ;
            endcase
        end
    end

    assign value_clear = acc.wr & (acc.sel == REG_VALUE);
    assign ctrl_read   = acc.rd & (acc.sel == REG_CTRL);

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            case (acc.sel)
                REG_CTRL:   bus_rdata = pack_ctrl(ctrl_q, count_flag);
                REG_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload_q};
                REG_VALUE:  bus_rdata = {{PAD_W{1'b0}}, cur_value};
                REG_CALIB:  bus_rdata = {{PAD_W{1'b0}}, CALIB_VALUE};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign ctrl   = ctrl_q;
    assign reload = reload_q;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CW];
endmodule

// File: rtl/tick_counter.sv
// Down counter with zero-crossing reload, sticky flag and interrupt pulse.
module tick_counter #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          count_en,
    input  logic          value_clear,
    input  logic          ctrl_read,
    input  logic          irq_en,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] value,
    output logic          flag,
    output logic          irq
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] value_q;
    logic          flag_q;
    logic          irq_q;
    logic          step;
    logic          hit;

    assign step = count_en & ~value_clear;
    assign hit  = step & (value_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (value_clear) begin
            value_q <= '0;
        end else if (step) begin
            if (value_q == '0) begin
                value_q <= reload;
            end else begin
                value_q <= value_q - ONE;
            end
        end
    end

    // A set in the same cycle as a clearing read takes priority.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (value_clear) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (ctrl_read) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit & irq_en;
        end
    end

    assign value = value_q;
    assign flag  = flag_q;
    assign irq   = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int               CW          = CNT_W,
    parameter int               REF_DIV     = 2,
    parameter logic [CW-1:0]    CALIB_VALUE = CW'(99999)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                tick_irq
);
    ctrl_t         ctrl_q;
    logic [CW-1:0] reload_q;
    logic [CW-1:0] cur_value;
    logic          count_flag;
    logic          value_clear;
    logic          ctrl_read;
    logic          ref_pulse;
    logic          count_en;

    tick_ref_enable #(.DIV(REF_DIV)) u_ref (
        .clk   (clk),
        .rst   (rst),
        .pulse (ref_pulse)
    );

    tick_regs #(.CW(CW), .CALIB_VALUE(CALIB_VALUE)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cur_value   (cur_value),
        .count_flag  (count_flag),
        .ctrl        (ctrl_q),
        .reload      (reload_q),
        .value_clear (value_clear),
        .ctrl_read   (ctrl_read),
        .bus_rdata   (bus_rdata)
    );

    // Clock-source mux expressed as a count enable
    assign count_en = ctrl_q.run & (ctrl_q.clk_src | ref_pulse);

    tick_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .count_en    (count_en),
        .value_clear (value_clear),
        .ctrl_read   (ctrl_read),
        .irq_en      (ctrl_q.irq_en),
        .reload      (reload_q),
        .value       (cur_value),
        .flag        (count_flag),
        .irq         (tick_irq)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] value,
    input logic [CW-1:0] reload,
    input logic          flag,
    input logic          irq,
    input logic          count_en,
    input logic          clk_src,
    input logic          value_clear
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);                                                  // R6
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);                                                  // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !value_clear) |=> $stable(value));                // R4
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_en && !value_clear && value != '0) |=> (value == $past(value) - 1'b1)); // R2
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count_en && !value_clear && value == '0) |=> (value == $past(reload))); // R8
    AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (rst)
        value_clear |=> (value == '0 && !flag));                        // R7
    AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
        (count_en && !clk_src) |=> !(count_en && !clk_src));            // R3
endmodule

bind tick_timer tick_timer_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .value       (cur_value),
    .reload      (reload_q),
    .flag        (count_flag),
    .irq         (tick_irq),
    .count_en    (count_en),
    .clk_src     (ctrl_q.clk_src),
    .value_clear (value_clear)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    localparam logic [23:0] CAL = 24'd99999;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int failures = 0;

    // Reference state, updated from the requirements
    logic [23:0] m_cur = '0, m_reload = '0;
    logic        m_flag = 0, m_run = 0, m_ie = 0, m_src = 0, m_half = 0, m_irq = 0;

    tick_timer u_tick_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0:    return {15'd0, m_flag, 13'd0, m_src, m_ie, m_run};
            4'h4:    return {8'd0, m_reload};
            4'h8:    return {8'd0, m_cur};
            4'hC:    return {8'd0, CAL};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        case (a)
            4'h0:    return "R5";
            4'h4:    return "R10";
            4'h8:    return "R2";
            4'hC:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_edge(input logic s, input logic w, input logic [3:0] a, input logic [31:0] d);
        logic cen, hit, cvr_wr, rd_ctrl;
        cvr_wr  = s && w && a == 4'h8;
        rd_ctrl = s && !w && a == 4'h0;
        cen     = m_run && (m_src || m_half);
        hit     = 1'b0;
        if (cvr_wr) begin
            m_cur = '0; m_flag = 1'b0;
        end else begin
            if (cen) begin
                if (m_cur == 0) m_cur = m_reload;
                else begin
                    if (m_cur == 1) hit = 1'b1;
                    m_cur = m_cur - 1;
                end
            end
            if (hit) m_flag = 1'b1;
            else if (rd_ctrl) m_flag = 1'b0;
        end
        m_irq  = hit && m_ie;
        m_half = ~m_half;
        if (s && w && a == 4'h0) begin
            m_run = d[0]; m_ie = d[1]; m_src = d[2];
        end
        if (s && w && a == 4'h4) m_reload = d[23:0];
    endtask

    task automatic step(input logic s, input logic w, input logic [3:0] a,
                        input logic [31:0] d, input string req);
        bus_sel = s; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        if (s && !w) check(req, bus_rdata, exp_read(a));
        else check("R10", bus_rdata, 32'd0);
        check("R6", {31'd0, tick_irq}, {31'd0, m_irq});
        @(posedge clk);
        model_edge(s, w, a, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        step(1'b1, 1'b1, a, d, req);
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        step(1'b1, 1'b0, a, 32'd0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_half = 1'b0;

        // R1: reset state
        rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1");
        // R9: calibration constant, write ignored
        rd(4'hC, "R9"); wr(4'hC, 32'hFFFF_FFFF, "R9"); rd(4'hC, "R9");
        // R10: reload width, flag not writable, unmapped offset
        wr(4'h4, 32'hFFFF_FFFF, "R10"); rd(4'h4, "R10");
        wr(4'h0, 32'hFFFF_FFF8, "R10"); rd(4'h0, "R10"); rd(4'h2, "R10");
        // R2: full rate, reload 4
        wr(4'h4, 32'd4, "R2"); wr(4'h8, 32'd0, "R2"); wr(4'h0, 32'h7, "R2");
        for (int i = 0; i < 12; i++) rd(4'h8, "R2");
        // R5: read flag every cycle, hits the set/clear overlap
        for (int i = 0; i < 12; i++) rd(4'h0, "R5");
        // R3: half rate
        wr(4'h0, 32'h3, "R3");
        for (int i = 0; i < 14; i++) rd(4'h8, "R3");
        // R4: stopped
        wr(4'h0, 32'h6, "R4");
        for (int i = 0; i < 6; i++) rd(4'h8, "R4");
        // R6: interrupt disabled, then enabled
        wr(4'h0, 32'h5, "R6");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 4'h0, 32'd0, "R6");
        wr(4'h0, 32'h7, "R6");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 4'h0, 32'd0, "R6");
        // R7: clear current value mid-period
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'h0, 32'd0, "R7");
        wr(4'h8, 32'h1234, "R7"); rd(4'h0, "R7");
        for (int i = 0; i < 4; i++) rd(4'h8, "R7");
        // R8: zero reload stops ticks
        wr(4'h4, 32'd0, "R8"); wr(4'h8, 32'd0, "R8");
        for (int i = 0; i < 10; i++) rd(4'h8, "R8");
        rd(4'h0, "R8");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [3:0] a;
            op = int'($urandom % 10);
            case (op)
                0: wr(4'h0, {29'd0, 3'($urandom)}, "R10");
                1: wr(4'h4, $urandom % 12, "R10");
                2: wr(4'h8, $urandom, "R7");
                3, 4, 5, 6: begin
                    case ($urandom % 5)
                        0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8;
                        3: a = 4'hC; default: a = 4'h6;
                    endcase
                    rd(a, tag_for(a));
                end
                default: step(1'b0, 1'b0, 4'h0, 32'd0, "R6");
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule